// File: doc/BRIEF.md
# Processor exception entry sequencer

This block performs the single architectural step that turns an accepted exception request into a handler entry for a small embedded 32-bit core. Given the requested exception kind, the current program counter, the current machine status word, the processor version value, the vector prefix register and a fault datum (a faulting address or a faulting instruction word), it decides the final exception kind. That decision may turn a storage, alignment or program fault into a machine check. It then forms the handler fetch address and updates the save/restore pair, the interrupt status register, the error data register and the new status word, all in one clock edge.

The surrounding core presents a request with a one-cycle valid strobe and follows the registered redirect. A machine check taken while machine checks are disabled halts the core: the block raises a sticky checkstop and ignores all later requests until reset. Pipeline flush, the return path and the timers are outside the block.

Top module: `exc_entry`

## Requirements
- R1: Kind codes on `req_type_i` are 0 machine check, 1 reset, 2 data storage, 3 instruction storage, 4 external, 5 alignment, 6 program, 7 decrementer, 8 fixed-interval timer, 9 watchdog. Kinds 1 to 9 use handler offset 0x40 + 0x20*(kind-1), so 0x40 for reset up to 0x140 for watchdog. The redirect address is the offset ORed with `ivpr_i & 0xFFFFFE00`.
- R2: The machine check offset is 0x00 when bits 23:20 of `pvr_i` are zero and 0x20 otherwise.
- R3: After reset `redirect_pc_o` is 0x40 and every other output is zero.
- R4: On every entry of a defined kind, including one that ends in checkstop, `srr0_o` takes `pc_i` and `srr1_o` takes the whole of `msr_i`.
- R5: The new status word `msr_o` keeps only the ME bit (bit 12) and the keep field (bits 29:27) of `msr_i`, with all other bits zero. ME is also cleared when the final kind is reset or machine check.
- R6: When the UIE bit (bit 6) of `msr_i` is 0, kinds 2, 3, 5 and 6 become machine checks. The sub-cause code goes to `isr_o[2:0]`: 1 for data storage, 2 for instruction storage, 3 for alignment and 4 for program.
- R7: A requested machine check writes sub-cause 0 (instruction-caused). Every machine check entry clears the MFE bit `isr_o[3]`.
- R8: A final machine check with ME clear sets `checkstop_o` and produces no redirect, and `msr_o` and `redirect_pc_o` stay unchanged. `checkstop_o` then holds until reset, and all later requests are ignored.
- R9: A program entry sets `isr_o[4]` (trap flag) to `trap_i`, where 1 means trap and 0 means illegal instruction, and loads `fault_data_i` (the instruction word) into `edr_o`. This happens even when the entry is promoted.
- R10: An alignment entry loads `fault_data_i` (the address) into `edr_o` and sets `isr_o[5]` to `store_i`, where 1 means store and 0 means load, even when promoted. Other kinds leave `edr_o` and these two flags unchanged.
- R11: A request with kind 10 to 15 pulses `bad_type_o` for one cycle and changes no register output.
- R12: Outputs change only at the edge that samples `req_valid_i` high. `redirect_valid_o` is a one-cycle pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Exception request strobe |
| req_type_i | input | 4 | Requested exception kind |
| trap_i | input | 1 | Program fault is a trap (1) or illegal instruction (0) |
| store_i | input | 1 | Alignment fault is a store (1) or load (0) |
| pc_i | input | 32 | Current program counter |
| msr_i | input | 32 | Current machine status word |
| pvr_i | input | 32 | Processor version value |
| ivpr_i | input | 32 | Vector prefix register |
| fault_data_i | input | 32 | Faulting address or instruction word |
| redirect_valid_o | output | 1 | Handler redirect pulse |
| redirect_pc_o | output | 32 | Handler fetch address |
| msr_o | output | 32 | New machine status word |
| srr0_o | output | 32 | Saved program counter |
| srr1_o | output | 32 | Saved status word |
| isr_o | output | 32 | Interrupt status register |
| edr_o | output | 32 | Error data register |
| checkstop_o | output | 1 | Sticky halt flag |
| bad_type_o | output | 1 | Undefined kind pulse |

## Verification
The bench builds the block with its default parameters: 32-bit words, the version field at bits 23:20, ME at bit 12, UIE at bit 6 and a three-bit keep field at 29:27. With that layout the bench sweeps all sixteen kind codes against both UIE values, both ME values, zero and non-zero version fields and all four trap/store pairs. This covers every promotion, every checkstop path and every undefined code. The interrupt status and error data registers carry their state from one request to the next, so the bench also checks that kinds which must not touch them leave them unchanged, and that requests after a checkstop are ignored.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int unsigned KIND_W = 4;
  localparam int unsigned MCS_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    EK_MCHK  = 4'd0,
    EK_RESET = 4'd1,
    EK_DSTOR = 4'd2,
    EK_ISTOR = 4'd3,
    EK_EXT   = 4'd4,
    EK_ALIGN = 4'd5,
    EK_PROG  = 4'd6,
    EK_DECR  = 4'd7,
    EK_FIT   = 4'd8,
    EK_WDOG  = 4'd9
  } exc_kind_e;

  localparam logic [KIND_W-1:0] KIND_LAST = 4'd9;

  typedef enum logic [MCS_W-1:0] {
    MCS_INSN  = 3'd0,
    MCS_DSTOR = 3'd1,
    MCS_ISTOR = 3'd2,
    MCS_ALIGN = 3'd3,
    MCS_PROG  = 3'd4
  } mcs_e;

  // interrupt status register layout
  localparam int unsigned ISR_MCS_LSB = 0;
  localparam int unsigned ISR_MFE     = 3;
  localparam int unsigned ISR_PTR     = 4;
  localparam int unsigned ISR_ST      = 5;

endpackage

// File: rtl/exc_resolve.sv
module exc_resolve
  import exc_entry_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic              uie_i,
  output logic              known_o,
  output exc_kind_e         final_o,
  output mcs_e              mcs_o
);

  logic promote;

  always_comb begin
    known_o = (kind_i <= KIND_LAST);
    promote = 1'b0;
    mcs_o   = MCS_INSN;
    unique case (kind_i)
      EK_DSTOR: begin promote = !uie_i; mcs_o = MCS_DSTOR; end
      EK_ISTOR: begin promote = !uie_i; mcs_o = MCS_ISTOR; end
      EK_ALIGN: begin promote = !uie_i; mcs_o = MCS_ALIGN; end
      EK_PROG:  begin promote = !uie_i; mcs_o = MCS_PROG;  end
      default:  ;
    endcase
    if (!promote) mcs_o = MCS_INSN;
    final_o = promote ? EK_MCHK : exc_kind_e'(kind_i);
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int unsigned      XLEN        = 32,
  parameter int unsigned      VER_W       = 4,
  parameter logic [XLEN-1:0]  PREFIX_MASK = 32'hFFFF_FE00
) (
  input  exc_kind_e       kind_i,
  input  logic [VER_W-1:0] ver_i,
  input  logic [XLEN-1:0] ivpr_i,
  output logic [XLEN-1:0] handler_o
);

  logic [XLEN-1:0] offset;

  always_comb begin
    unique case (kind_i)
      EK_MCHK:  offset = (ver_i == '0) ? XLEN'(9'h000) : XLEN'(9'h020);
      EK_RESET: offset = XLEN'(9'h040);
      EK_DSTOR: offset = XLEN'(9'h060);
      EK_ISTOR: offset = XLEN'(9'h080);
      EK_EXT:   offset = XLEN'(9'h0A0);
      EK_ALIGN: offset = XLEN'(9'h0C0);
      EK_PROG:  offset = XLEN'(9'h0E0);
      EK_DECR:  offset = XLEN'(9'h100);
      EK_FIT:   offset = XLEN'(9'h120);
      EK_WDOG:  offset = XLEN'(9'h140);
      default:  offset = '0;
    endcase
  end

  assign handler_o = offset | (ivpr_i & PREFIX_MASK);

endmodule

// File: rtl/exc_isr_upd.sv
module exc_isr_upd
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   cur_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              mchk_i,
  input  mcs_e              mcs_i,
  input  logic              trap_i,
  input  logic              store_i,
  output logic [XLEN-1:0]   nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    if (kind_i == EK_PROG)  nxt_o[ISR_PTR] = trap_i;
    if (kind_i == EK_ALIGN) nxt_o[ISR_ST]  = store_i;
    if (mchk_i) begin
      nxt_o[ISR_MCS_LSB +: MCS_W] = mcs_i;
      nxt_o[ISR_MFE]              = 1'b0;
    end
  end

endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     VER_LSB     = 20,
  parameter int unsigned     VER_W       = 4,
  parameter logic [XLEN-1:0] PREFIX_MASK = 32'hFFFF_FE00,
  parameter logic [XLEN-1:0] BOOT_ADDR   = 32'h0000_0040,
  parameter int unsigned     ME_POS      = 12,
  parameter int unsigned     UIE_POS     = 6,
  parameter int unsigned     KEEP_LSB    = 27,
  parameter int unsigned     KEEP_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [KIND_W-1:0] req_type_i,
  input  logic              trap_i,
  input  logic              store_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   pvr_i,
  input  logic [XLEN-1:0]   ivpr_i,
  input  logic [XLEN-1:0]   fault_data_i,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   isr_o,
  output logic [XLEN-1:0]   edr_o,
  output logic              checkstop_o,
  output logic              bad_type_o
);

  localparam logic [XLEN-1:0] KEEP_MASK =
      (((XLEN'(1) << KEEP_W) - XLEN'(1)) << KEEP_LSB) | (XLEN'(1) << ME_POS);

  logic            known;
  exc_kind_e       fin_kind;
  mcs_e            mcs;
  logic [XLEN-1:0] handler;
  logic [XLEN-1:0] isr_nxt;
  logic [XLEN-1:0] msr_nxt;
  logic            is_mchk, accept, halt, go;
  logic            unused_pvr;

  assign unused_pvr = ^pvr_i;

  exc_resolve u_resolve (
    .kind_i  (req_type_i),
    .uie_i   (msr_i[UIE_POS]),
    .known_o (known),
    .final_o (fin_kind),
    .mcs_o   (mcs)
  );

  exc_vector #(
    .XLEN        (XLEN),
    .VER_W       (VER_W),
    .PREFIX_MASK (PREFIX_MASK)
  ) u_vector (
    .kind_i    (fin_kind),
    .ver_i     (pvr_i[VER_LSB +: VER_W]),
    .ivpr_i    (ivpr_i),
    .handler_o (handler)
  );

  assign is_mchk = (fin_kind == EK_MCHK);

  exc_isr_upd #(.XLEN(XLEN)) u_isr (
    .cur_i   (isr_o),
    .kind_i  (req_type_i),
    .mchk_i  (is_mchk),
    .mcs_i   (mcs),
    .trap_i  (trap_i),
    .store_i (store_i),
    .nxt_o   (isr_nxt)
  );

  always_comb begin
    msr_nxt = msr_i & KEEP_MASK;
    if (is_mchk || fin_kind == EK_RESET) msr_nxt[ME_POS] = 1'b0;
  end

  assign accept = req_valid_i && !checkstop_o && known;
  assign halt   = accept && is_mchk && !msr_i[ME_POS];
  assign go     = accept && !halt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= BOOT_ADDR;
      msr_o            <= '0;
      srr0_o           <= '0;
      srr1_o           <= '0;
      isr_o            <= '0;
      edr_o            <= '0;
      checkstop_o      <= 1'b0;
      bad_type_o       <= 1'b0;
    end else begin
      redirect_valid_o <= go;
      bad_type_o       <= req_valid_i && !checkstop_o && !known;
      if (accept) begin
        srr0_o <= pc_i;
        srr1_o <= msr_i;
        isr_o  <= isr_nxt;
        if (req_type_i == EK_PROG || req_type_i == EK_ALIGN) edr_o <= fault_data_i;
      end
      if (go) begin
        msr_o         <= msr_nxt;
        redirect_pc_o <= handler;
      end
      if (halt) checkstop_o <= 1'b1;
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned     XLEN        = 32,
  parameter logic [XLEN-1:0] PREFIX_MASK = 32'hFFFF_FE00,
  parameter int unsigned     ME_POS      = 12,
  parameter int unsigned     KEEP_LSB    = 27,
  parameter int unsigned     KEEP_W      = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [3:0]      req_type_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] msr_i,
  input logic [XLEN-1:0] ivpr_i,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] msr_o,
  input logic [XLEN-1:0] srr0_o,
  input logic [XLEN-1:0] srr1_o,
  input logic            checkstop_o,
  input logic            bad_type_o
);

  localparam logic [XLEN-1:0] KEEP_MASK =
      (((XLEN'(1) << KEEP_W) - XLEN'(1)) << KEEP_LSB) | (XLEN'(1) << ME_POS);

  p_vec_prefix_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> ((redirect_pc_o & PREFIX_MASK) == ($past(ivpr_i) & PREFIX_MASK)));

  p_srr_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !checkstop_o && req_type_i <= 4'd9)
      |=> (srr0_o == $past(pc_i) && srr1_o == $past(msr_i)));

  p_msr_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> ((msr_o & ~KEEP_MASK) == '0));

  p_halt_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(checkstop_o) |-> !$past(msr_i[ME_POS]));

  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> checkstop_o);

  p_halt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |-> !redirect_valid_o);

  p_bad_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_type_o |-> ($stable(srr0_o) && $stable(srr1_o) && !redirect_valid_o));

  p_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> $past(req_valid_i));

endmodule

bind exc_entry exc_entry_chk #(
  .XLEN        (XLEN),
  .PREFIX_MASK (PREFIX_MASK),
  .ME_POS      (ME_POS),
  .KEEP_LSB    (KEEP_LSB),
  .KEEP_W      (KEEP_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_type_i       (req_type_i),
  .pc_i             (pc_i),
  .msr_i            (msr_i),
  .ivpr_i           (ivpr_i),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .msr_o            (msr_o),
  .srr0_o           (srr0_o),
  .srr1_o           (srr1_o),
  .checkstop_o      (checkstop_o),
  .bad_type_o       (bad_type_o)
);

// File: tb/exc_entry_bench.sv
module exc_entry_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_type_i = '0;
  logic        trap_i = 1'b0, store_i = 1'b0;
  logic [31:0] pc_i = '0, msr_i = '0, pvr_i = '0, ivpr_i = '0, fault_data_i = '0;
  logic        redirect_valid_o, checkstop_o, bad_type_o;
  logic [31:0] redirect_pc_o, msr_o, srr0_o, srr1_o, isr_o, edr_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] e_pc, e_msr, e_srr0, e_srr1, e_isr, e_edr;
  logic        e_halt, e_rv, e_bad;

  always #5 clk = ~clk;

  exc_entry u_exc_entry (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_type_i(req_type_i),
    .trap_i(trap_i), .store_i(store_i), .pc_i(pc_i), .msr_i(msr_i), .pvr_i(pvr_i),
    .ivpr_i(ivpr_i), .fault_data_i(fault_data_i), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o), .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .isr_o(isr_o), .edr_o(edr_o), .checkstop_o(checkstop_o), .bad_type_o(bad_type_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R12 redirect_valid", {31'd0, redirect_valid_o}, {31'd0, e_rv});
    chk("R1/R2 redirect_pc", redirect_pc_o, e_pc);
    chk("R5 msr_o", msr_o, e_msr);
    chk("R4 srr0", srr0_o, e_srr0);
    chk("R4 srr1", srr1_o, e_srr1);
    chk("R6/R7/R9/R10 isr", isr_o, e_isr);
    chk("R9/R10 edr", edr_o, e_edr);
    chk("R8 checkstop", {31'd0, checkstop_o}, {31'd0, e_halt});
    chk("R11 bad_type", {31'd0, bad_type_o}, {31'd0, e_bad});
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    e_pc = 32'h40; e_msr = '0; e_srr0 = '0; e_srr1 = '0; e_isr = '0; e_edr = '0;
    e_halt = 1'b0; e_rv = 1'b0; e_bad = 1'b0;
    @(negedge clk);
    chk("R3 reset redirect_pc", redirect_pc_o, 32'h40);
    check_all();
  endtask

  task automatic do_req(input logic [3:0] kind, input logic trap, input logic store,
                        input logic [31:0] pc, input logic [31:0] msr,
                        input logic [31:0] pvr, input logic [31:0] ivpr,
                        input logic [31:0] fd);
    logic        promote;
    logic [3:0]  fin;
    logic [2:0]  mcs;
    logic [31:0] off;
    @(negedge clk);
    req_valid_i = 1'b1; req_type_i = kind; trap_i = trap; store_i = store;
    pc_i = pc; msr_i = msr; pvr_i = pvr; ivpr_i = ivpr; fault_data_i = fd;
    e_rv = 1'b0; e_bad = 1'b0;
    if (!e_halt) begin
      if (kind > 4'd9) begin
        e_bad = 1'b1;
      end else begin
        promote = !msr[6] && (kind == 4'd2 || kind == 4'd3 || kind == 4'd5 || kind == 4'd6);
        fin = promote ? 4'd0 : kind;
        mcs = 3'd0;
        if (promote) mcs = (kind == 4'd2) ? 3'd1 : (kind == 4'd3) ? 3'd2 : (kind == 4'd5) ? 3'd3 : 3'd4;
        e_srr0 = pc;
        e_srr1 = msr;
        if (kind == 4'd6) begin e_isr[4] = trap;  e_edr = fd; end
        if (kind == 4'd5) begin e_isr[5] = store; e_edr = fd; end
        if (fin == 4'd0) begin e_isr[2:0] = mcs; e_isr[3] = 1'b0; end
        if (fin == 4'd0 && !msr[12]) begin
          e_halt = 1'b1;
        end else begin
          e_rv = 1'b1;
          if (fin == 4'd0) off = (pvr[23:20] == 4'd0) ? 32'h0 : 32'h20;
          else             off = 32'h40 + 32'h20 * (32'(fin) - 32'd1);
          e_pc  = off | (ivpr & 32'hFFFF_FE00);
          e_msr = msr & 32'h3800_1000;
          if (fin <= 4'd1) e_msr[12] = 1'b0;
        end
      end
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    check_all();
    e_rv = 1'b0; e_bad = 1'b0;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] m, pv;
    n = 0;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      for (int uie = 0; uie < 2; uie++) begin
        for (int me = 0; me < 2; me++) begin
          for (int ver = 0; ver < 2; ver++) begin
            for (int ts = 0; ts < 4; ts++) begin
              m = 32'h9E37_79B9 * 32'(n + 1);
              m[6]  = uie[0];
              m[12] = me[0];
              pv = (ver == 0) ? 32'h0F0F_FFFF : (32'h0030_0000 | 32'(n));
              do_req(4'(k), ts[0], ts[1], 32'h1000_0000 + 32'(n) * 4, m, pv,
                     32'hDEAD_BEEF ^ (32'(n) * 32'h0101_0101), 32'hC0DE_0000 | 32'(n));
              if (e_halt) begin
                // R8: request after halt must be ignored
                do_req(4'd6, 1'b1, 1'b1, 32'h2222_0000, 32'hFFFF_FFFF, 32'h0,
                       32'h1234_5600, 32'h5555_AAAA);
                do_req(4'd12, 1'b0, 1'b0, 32'h3333_0000, 32'h0, 32'h0, 32'h0, 32'h0);
                do_reset();
              end
              n++;
            end
          end
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule